// File: doc/BRIEF.md
# RS-485 UART Transmitter with Self-Timed Driver Enable

This block serialises bytes for a half-duplex differential bus and controls the transceiver's driver-enable line itself. Bytes written by the host pass through a parameterised queue and a single hold register into a shift register. The shift register sends each byte with one start bit, eight data bits sent least significant bit first, and one stop bit. The enable line rises one bit period before the first start bit. It falls in the same cycle that the stop bit of the last queued byte completes. Because the turn-off follows the real occupancy of the queue, hold register and shifter, a lone acknowledge byte gets exactly its own frame time and no extra character time.

The host sees a queue-full flag, which only governs whether another write is accepted. It also sees a line-idle flag, a sticky overflow flag and a one-cycle interrupt pulse when the line goes idle. The bit period comes from a 16-bit divisor input, which the block samples only while it is idle.

Top module: `uart_de_tx`

## Requirements
- R1: Each byte leaves on `txd` as one low start bit, eight data bits least significant bit first, and one high stop bit. Each bit lasts `divisor` clock cycles, and a divisor of 0 behaves as 1.
- R2: A byte written while the block is idle raises `de` two clock edges after the write edge. `de` then stays high for one bit period with `txd` high before the start bit. `de` is low before that.
- R3: `de` falls in the very cycle the stop bit of the last queued byte ends. For n bytes sent in one burst, `de` is high for exactly (1 + 10·n) bit periods, so a single byte holds it for 11 bit periods.
- R4: Queued bytes follow one another with no idle bit and no drop of `de`. A byte accepted at least two clock edges before the edge that ends the current stop bit is chained straight into the next frame.
- R5: `fifo_full` is high when the queue holds FIFO_DEPTH bytes. A write while it is high is discarded and sets `overflow`, which stays set until reset.
- R6: `tx_empty` is high exactly when the queue, the hold register and the shifter are all empty, and it is low for the whole of any transmission.
- R7: `irq_empty` is a single-cycle pulse in the cycle `tx_empty` rises.
- R8: The divisor is sampled only while `tx_empty` is high. A change during transmission leaves the current bit timing unchanged and takes effect from the next idle period.
- R9: After reset, `de`=0, `txd`=1, `tx_empty`=1, `fifo_full`=0, `overflow`=0 and `irq_empty`=0. Whenever `de` is low, `txd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| divisor | input | 16 | Clock cycles per bit, sampled while idle |
| fifo_full | output | 1 | Queue cannot take another byte |
| tx_empty | output | 1 | Queue, hold register and shifter all empty |
| overflow | output | 1 | Sticky: a write was discarded |
| irq_empty | output | 1 | One-cycle pulse when the line becomes idle |
| txd | output | 1 | Serial data, idle high |
| de | output | 1 | Transceiver driver enable |

## Verification
Two functions can land on the same clock edge: the end-of-frame turn-off of `de` together with the `irq_empty` pulse, and the chaining of a byte that arrives during the last stop bit. The bench provokes this by writing the second byte of a message at chosen cycles inside the first byte's stop bit. It checks every cycle that `de` never drops, that no interrupt fires, and that the second start bit follows the first stop bit with no gap. Single-byte and burst messages are compared cycle by cycle against a timeline computed from the divisor and the byte count, to judge the exact turn-off cycle.

// File: rtl/uart_de_pkg.sv
`timescale 1ns/1ps
// Shared constants and state type for the driver-enable UART transmitter.
package uart_de_pkg;
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LEAD,
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_t;
endpackage

// File: rtl/uart_de_fifo.sv
`timescale 1ns/1ps
// Synchronous byte queue of parameterised depth.
// Assumes: a push while full is ignored (the caller flags it); a pop while
// empty is ignored; a push and a pop may happen in the same cycle.
module uart_de_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_de_baud.sv
`timescale 1ns/1ps
// Bit-period tick generator. While run is high it emits one tick every
// div clock cycles (div of 0 acts as 1); while run is low it holds its
// count at zero so the first bit after start-up has full length.
module uart_de_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign tick    = run && (cnt == div_eff - 1'b1);

    // Cycle counter within one bit period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_de_shifter.sv
`timescale 1ns/1ps
// Frame shifter: lead-in bit, start bit, data bits LSB first, stop bit.
// Assumes the hold stage presents hold_v/hold_d; take tells it the byte
// was consumed. The lead-in is only inserted when starting from idle, so
// back-to-back bytes are sent with no gap.
module uart_de_shifter
    import uart_de_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 hold_v,
    input  logic [DATA_BITS-1:0] hold_d,
    output logic                 take,
    output logic                 busy,
    output logic                 txd
);
    localparam int BW = $clog2(DATA_BITS);

    sh_state_t            state;
    logic [DATA_BITS-1:0] sreg;
    logic [BW-1:0]        bitcnt;

    assign busy = (state != SH_IDLE);

    // Consume the held byte on start from idle or at the end of a stop bit
    always_comb begin
        take = hold_v && ((state == SH_IDLE) || (state == SH_STOP && tick));
    end

    // Serial output level for the current state
    always_comb begin
        case (state)
            SH_START: txd = 1'b0;
            SH_DATA:  txd = sreg[0];
            default:  txd = 1'b1;
        endcase
    end

    // Frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SH_IDLE;
            sreg   <= '0;
            bitcnt <= '0;
        end else begin
            case (state)
                SH_IDLE: if (hold_v) begin
                    sreg  <= hold_d;
                    state <= SH_LEAD;
                end
                SH_LEAD: if (tick) state <= SH_START;
                SH_START: if (tick) begin
                    bitcnt <= '0;
                    state  <= SH_DATA;
                end
                SH_DATA: if (tick) begin
                    sreg   <= sreg >> 1;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == BW'(DATA_BITS - 1)) state <= SH_STOP;
                end
                SH_STOP: if (tick) begin
                    if (hold_v) begin
                        sreg  <= hold_d;
                        state <= SH_START;
                    end else begin
                        state <= SH_IDLE;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_de_tx.sv
`timescale 1ns/1ps
// UART transmitter with automatic RS-485 driver enable.
// Path: queue -> hold register -> shifter. de is high whenever the shifter
// is busy, so it drops exactly when the last stop bit ends. The divisor is
// captured only while the whole path is empty.
// Assumes: wr_en is a one-cycle strobe per byte.
module uart_de_tx
    import uart_de_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic [DIV_W-1:0]     divisor,
    output logic                 fifo_full,
    output logic                 tx_empty,
    output logic                 overflow,
    output logic                 irq_empty,
    output logic                 txd,
    output logic                 de
);
    logic [DATA_BITS-1:0] q_dout;
    logic                 q_empty, q_pop;
    logic                 hold_v;
    logic [DATA_BITS-1:0] hold_d;
    logic                 take, busy, tick;
    logic [DIV_W-1:0]     div_q;
    logic                 empty_q;

    uart_de_fifo #(.WIDTH(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .din(wr_data),
        .pop(q_pop), .dout(q_dout),
        .empty(q_empty), .full(fifo_full)
    );

    uart_de_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
    );

    uart_de_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hold_v(hold_v), .hold_d(hold_d),
        .take(take), .busy(busy), .txd(txd)
    );

    assign q_pop     = !q_empty && (!hold_v || take);
    assign tx_empty  = q_empty && !hold_v && !busy;
    assign de        = busy;
    assign irq_empty = tx_empty && !empty_q;

    // Hold register: refilled from the queue, emptied by the shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (q_pop) begin
            hold_v <= 1'b1;
            hold_d <= q_dout;
        end else if (take) begin
            hold_v <= 1'b0;
        end
    end

    // Divisor capture while idle, sticky overflow, idle-edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= DIV_W'(1);
            overflow <= 1'b0;
            empty_q  <= 1'b1;
        end else begin
            if (tx_empty)            div_q    <= divisor;
            if (wr_en && fifo_full)  overflow <= 1'b1;
            empty_q <= tx_empty;
        end
    end
endmodule

// File: rtl/uart_de_tx_chk.sv
`timescale 1ns/1ps
// Property checker for uart_de_tx, attached by bind.
module uart_de_tx_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             fifo_full,
    input logic             tx_empty,
    input logic             overflow,
    input logic             irq_empty,
    input logic             txd,
    input logic             de,
    input logic [DIV_W-1:0] div_q
);
    assert_start_under_de_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> de);
    assert_line_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> txd);
    assert_release_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> txd);
    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !de);
    assert_irq_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> $rose(tx_empty));
    assert_overflow_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_full) |=> overflow);
    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_divisor_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_empty |=> $stable(div_q));
endmodule

bind uart_de_tx uart_de_tx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_full(fifo_full),
    .tx_empty(tx_empty), .overflow(overflow), .irq_empty(irq_empty),
    .txd(txd), .de(de), .div_q(div_q)
);

// File: tb/uart_de_tx_bench.sv
`timescale 1ns/1ps
// Cycle-exact bench: every output is compared each cycle with a timeline
// computed from the divisor, the byte count and the byte values.
module uart_de_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [15:0] divisor;
    logic        fifo_full, tx_empty, overflow, irq_empty, txd, de;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [7:0] tx_bytes [0:31];

    uart_de_tx u_uart_de_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .divisor(divisor), .fifo_full(fifo_full), .tx_empty(tx_empty),
        .overflow(overflow), .irq_empty(irq_empty), .txd(txd), .de(de)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 32; i++) tx_bytes[i] = 8'(seed * 37 + i * 91 + 5);
    endtask

    // nwr bytes written (upfront, or byte 0 then byte 1 at late_j), nexp sent
    task automatic run_case(input int nwr, input int nexp, input int late_j,
                            input int d, input int chg_j, input int chg_div,
                            input string rtxd);
        int total, p, q, b, k;
        logic e_de, e_txd;
        total = d * (1 + 10 * nexp);
        for (int j = -3; j <= total + 3; j++) begin
            @(negedge clk);
            if (j < 0 || j >= total) begin
                e_de = 1'b0; e_txd = 1'b1;
            end else begin
                e_de = 1'b1;
                p = j / d;
                if (p == 0) e_txd = 1'b1;
                else begin
                    q = p - 1; b = q / 10; k = q % 10;
                    if (k == 0)      e_txd = 1'b0;
                    else if (k == 9) e_txd = 1'b1;
                    else             e_txd = tx_bytes[b][k-1];
                end
            end
            chk(de === e_de, (j < 0) ? "R2" : (j >= total) ? "R3" : "R4", int'(de), int'(e_de));
            chk(txd === e_txd, rtxd, int'(txd), int'(e_txd));
            if (j >= 0) chk(tx_empty === (j >= total), "R6", int'(tx_empty), int'(j >= total));
            chk(irq_empty === (j == total), "R7", int'(irq_empty), int'(j == total));
            if (nwr > nexp && j == 14) chk(fifo_full === 1'b0, "R5", int'(fifo_full), 0);
            if (nwr > nexp && j == 15) chk(fifo_full === 1'b1, "R5", int'(fifo_full), 1);
            if (j == chg_j) divisor = 16'(chg_div);
            if (late_j < 0 && j + 3 < nwr) begin
                wr_en = 1'b1; wr_data = tx_bytes[j + 3];
            end else if (late_j >= 0 && (j == -3 || j == late_j)) begin
                wr_en = 1'b1; wr_data = tx_bytes[(j == -3) ? 0 : 1];
            end else begin
                wr_en = 1'b0;
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; divisor = 16'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(de === 1'b0,        "R9", int'(de), 0);
        chk(txd === 1'b1,       "R9", int'(txd), 1);
        chk(tx_empty === 1'b1,  "R9", int'(tx_empty), 1);
        chk(fifo_full === 1'b0, "R9", int'(fifo_full), 0);
        chk(overflow === 1'b0,  "R9", int'(overflow), 0);
        chk(irq_empty === 1'b0, "R9", int'(irq_empty), 0);

        fill(1); tx_bytes[0] = 8'hA5;
        run_case(1, 1, -1, 4, -100, 0, "R1");      // single byte, R3 turn-off
        fill(2);
        run_case(3, 3, -1, 4, -100, 0, "R1");      // burst of three
        fill(3);
        run_case(2, 2, 41, 4, -100, 0, "R4");      // late write chained
        fill(4);
        run_case(2, 2, 40, 4, -100, 0, "R4");
        fill(5);
        run_case(1, 1, -1, 4, 5, 7, "R8");         // divisor change mid-frame
        fill(6);
        run_case(2, 2, -1, 7, -100, 0, "R8");      // new divisor after idle
        @(negedge clk); divisor = 16'd0;
        fill(7);
        run_case(2, 2, -1, 1, -100, 0, "R1");      // divisor 0 acts as 1
        chk(overflow === 1'b0, "R5", int'(overflow), 0);
        @(negedge clk); divisor = 16'd4;
        fill(8);
        run_case(20, 18, -1, 4, -100, 0, "R5");    // two writes dropped
        chk(overflow === 1'b1, "R5", int'(overflow), 1);
        repeat (5) @(negedge clk);
        chk(overflow === 1'b1, "R5", int'(overflow), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule